// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned WIDTH-bit operands and returns a 2*WIDTH-bit product. It builds the product in place inside one long register made of a carry bit, an accumulator and a multiplier register. The carry and the accumulator start cleared, and the multiplier register starts with the multiplier. Each iteration looks at the lowest bit of the multiplier register. When that bit is 1, the multiplicand is added into the accumulator, and the adder's carry-out lands in the carry bit. The whole chain then moves one place to the right. Multiplier bits leave from the bottom while product bits enter from the top. After WIDTH iterations the accumulator holds the upper half of the product and the multiplier register holds the lower half.

A caller pulses `start_i` with the operands present while the block is idle. The block copies both operands on that edge and spends two cycles on each iteration, one for the conditional add and one for the shift. It then raises `done_o` for a single cycle. The product stays on `product_o` until the next operation is accepted.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `product_o` is all zeros.
- R2: Operands are copied on the rising edge that accepts `start_i`. Changing `mcand_i` or `mplier_i` afterwards does not alter the result.
- R3: For every operand pair, the value on `product_o` while `done_o` is high equals mcand * mplier as an unsigned 2*WIDTH-bit number (all 256 pairs at WIDTH=4).
- R4: `done_o` is high for exactly one cycle. It rises at the (2*WIDTH+1)-th rising edge, counting the edge that accepts `start_i` as the first (the 9th edge at WIDTH=4).
- R5: `busy_o` is 1 from the cycle after start is accepted through the `done_o` cycle inclusive. It is 0 otherwise.
- R6: `start_i` is ignored whenever `busy_o` is 1, including the `done_o` cycle. Such a start changes neither the result nor the timing, and the block is idle afterwards.
- R7: While idle with `start_i` low, `product_o` holds its last value.
- R8: The carry-out of the accumulator add is kept. 13 * 11 gives 143 (8'h8F) and 15 * 15 gives 225 (8'hE1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a multiplication; taken only when idle |
| mcand_i | input | WIDTH | Multiplicand, copied when start is accepted |
| mplier_i | input | WIDTH | Multiplier, copied when start is accepted |
| busy_o | output | 1 | Operation in progress, done cycle included |
| done_o | output | 1 | One-cycle pulse: product is valid |
| product_o | output | 2*WIDTH | {accumulator, multiplier register} |

## Verification
Two functions can fall in the same cycle: the completion pulse and the acceptance of a new request. The bench raises `start_i` with different operands on the cycle after an operation is accepted and keeps it high through the `done_o` cycle. It then checks three things: the first product and the 9-edge latency are unchanged, `busy_o` is low on the cycle after `done_o`, and no second operation began. The checker also asserts that a load never occurs while busy.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADD   = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } mul_state_e;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic lsb_i,
  output logic load_o,
  output logic add_o,
  output logic shift_o,
  output logic done_o,
  output logic busy_o
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  mul_state_e state_q, state_d;
  logic [CW-1:0] iter_q;
  logic last_iter;

  assign last_iter = (iter_q == LAST);
  assign load_o  = start_i && (state_q == ST_IDLE);
  assign add_o   = (state_q == ST_ADD) && lsb_i;
  assign shift_o = (state_q == ST_SHIFT);
  assign done_o  = (state_q == ST_DONE);
  assign busy_o  = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_ADD;
      ST_ADD:   state_d = ST_SHIFT;
      ST_SHIFT: state_d = last_iter ? ST_DONE : ST_ADD;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
    end else begin
      state_q <= state_d;
      if (load_o) iter_q <= '0;
      else if (shift_o) iter_q <= iter_q + 1'b1;
    end
  end
endmodule

// File: rtl/mul_chain.sv
module mul_chain #(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               add_i,
  input  logic               shift_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic               lsb_o,
  output logic [2*WIDTH-1:0] product_o
);
  localparam int CHAIN = 2 * WIDTH + 1;

  // conditional-add result: {carry, accumulator}
  function automatic logic [WIDTH:0] add_step(input logic [WIDTH-1:0] acc,
                                               input logic [WIDTH-1:0] m);
    return {1'b0, acc} + {1'b0, m};
  endfunction

  // one right shift of the whole carry/accumulator/multiplier chain
  function automatic logic [CHAIN-1:0] shift_step(input logic [CHAIN-1:0] chain);
    return {1'b0, chain[CHAIN-1:1]};
  endfunction

  logic [WIDTH-1:0] mcand_q;
  logic             carry_q;
  logic [WIDTH-1:0] acc_q;
  logic [WIDTH-1:0] mq_q;
  logic [WIDTH:0]   sum;
  logic [CHAIN-1:0] shifted;

  assign sum     = add_step(acc_q, mcand_q);
  assign shifted = shift_step({carry_q, acc_q, mq_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      carry_q <= 1'b0;
      acc_q   <= '0;
      mq_q    <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      carry_q <= 1'b0;
      acc_q   <= '0;
      mq_q    <= mplier_i;
    end else if (add_i) begin
      {carry_q, acc_q} <= sum;
    end else if (shift_i) begin
      {carry_q, acc_q, mq_q} <= shifted;
    end
  end

  assign lsb_o     = mq_q[0];
  assign product_o = {acc_q, mq_q};
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  // named internal events, observed by the bound checker
  logic load_ev;
  logic add_ev;
  logic shift_ev;
  logic lsb;

  mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .lsb_i   (lsb),
    .load_o  (load_ev),
    .add_o   (add_ev),
    .shift_o (shift_ev),
    .done_o  (done_o),
    .busy_o  (busy_o)
  );

  mul_chain #(.WIDTH(WIDTH)) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_ev),
    .add_i     (add_ev),
    .shift_i   (shift_ev),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .lsb_o     (lsb),
    .product_o (product_o)
  );
endmodule

// File: rtl/shift_add_mul_checker.sv
module shift_add_mul_checker #(
  parameter int WIDTH = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic [WIDTH-1:0]   mcand_i,
  input logic [WIDTH-1:0]   mplier_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [2*WIDTH-1:0] product_o,
  input logic               load_ev,
  input logic               add_ev,
  input logic               shift_ev
);
  logic [WIDTH-1:0] ref_a, ref_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_a <= '0;
      ref_b <= '0;
    end else if (load_ev) begin
      ref_a <= mcand_i;
      ref_b <= mplier_i;
    end
  end

  assert_product_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (product_o == (2*WIDTH)'(ref_a) * (2*WIDTH)'(ref_b)));

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(shift_ev));

  assert_busy_after_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> busy_o);

  assert_add_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (add_ev || shift_ev) |-> busy_o);

  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |-> !load_ev);

  assert_product_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(product_o));
endmodule

bind shift_add_mul shift_add_mul_checker #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .mcand_i   (mcand_i),
  .mplier_i  (mplier_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .product_o (product_o),
  .load_ev   (load_ev),
  .add_ev    (add_ev),
  .shift_ev  (shift_ev)
);

// File: tb/shift_add_mul_test.sv
`timescale 1ns/1ps
module shift_add_mul_test;
  localparam int W = 4;
  localparam int LAT = 2 * W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [W-1:0] mcand_i = '0, mplier_i = '0;
  logic busy_o, done_o;
  logic [2*W-1:0] product_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  shift_add_mul #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mcand_i(mcand_i),
    .mplier_i(mplier_i), .busy_o(busy_o), .done_o(done_o), .product_o(product_o)
  );

  // {a, b, expected product}
  localparam logic [15:0] VEC [10] = '{
    16'hDB8F, 16'hFFE1, 16'h0900, 16'h9000, 16'h1E0E,
    16'h8840, 16'h762A, 16'hC53C, 16'hF10F, 16'h1101
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference by repeated addition
  function automatic int ref_mul(input int a, input int b);
    int s = 0;
    for (int i = 0; i < b; i++) s += a;
    return s;
  endfunction

  // run one operation from an idle negedge; optionally hold a competing start
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke,
                        output int lat, output int prod, output bit busy_ok);
    start_i = 1'b1; mcand_i = a; mplier_i = b;
    @(negedge clk);
    lat = 1; busy_ok = 1'b1;
    start_i = poke; mcand_i = ~a; mplier_i = ~b;   // R2: inputs scrambled while busy
    while (!done_o && lat < 100) begin
      if (!busy_o) busy_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
    if (!busy_o) busy_ok = 1'b0;
    prod = int'(product_o);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    int lat, prod;
    bit bok;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy_o == 0, "R1 busy", busy_o, 0);
    check(done_o == 0, "R1 done", done_o, 0);
    check(product_o == 0, "R1 product", product_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table
    for (int v = 0; v < 10; v++) begin
      run_op(VEC[v][15:12], VEC[v][11:8], 1'b0, lat, prod, bok);
      check(prod == int'(VEC[v][7:0]), "R3/R8 table", prod, int'(VEC[v][7:0]));
    end

    // exhaustive, with scrambled inputs during busy (R2)
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        run_op(W'(a), W'(b), 1'b0, lat, prod, bok);
        check(prod == ref_mul(a, b), "R3 R2 exhaustive", prod, ref_mul(a, b));
      end
    end

    // R8 worked case and carry case
    run_op(4'd13, 4'd11, 1'b0, lat, prod, bok);
    check(prod == 143, "R8 13x11", prod, 143);
    // R4 latency and single pulse; R5 busy window
    check(lat == LAT, "R4 latency", lat, LAT);
    check(done_o == 0, "R4 single pulse", done_o, 0);
    check(bok, "R5 busy during op", bok, 1);
    check(busy_o == 0, "R5 idle after", busy_o, 0);
    run_op(4'd15, 4'd15, 1'b0, lat, prod, bok);
    check(prod == 225, "R8 15x15", prod, 225);

    // R6: start held high through the whole op including the done cycle
    run_op(4'd6, 4'd7, 1'b1, lat, prod, bok);
    check(prod == 42, "R6 product", prod, 42);
    check(lat == LAT, "R6 latency", lat, LAT);
    check(busy_o == 0, "R6 idle after done", busy_o, 0);
    @(negedge clk);
    check(busy_o == 0, "R6 no second op", busy_o, 0);
    check(product_o == 42, "R6 product kept", product_o, 42);

    // R7 product held while idle with inputs moving
    for (int k = 0; k < 6; k++) begin
      mcand_i = W'(k + 3); mplier_i = W'(k * 5);
      @(negedge clk);
    end
    check(product_o == 42, "R7 hold", product_o, 42);
    check(busy_o == 0 && done_o == 0, "R7 idle", {busy_o, done_o}, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule